// File: doc/BRIEF.md
# Mixed-Sign Multiply Unit

This block is the multiply stage of a 16-bit DSP datapath. Two 32-bit auxiliary operands each hold a high and a low 16-bit half. Each valid instruction word selects one half of each operand. From the halves selected and their top bits, the block picks a signed, unsigned or mixed-sign treatment. It then forms the product, doubled unless the status register's no-doubling bit is set, and writes it into a 40-bit product register.

Three of the four variants also touch one of two 40-bit accumulators, and they use the product value held from before the current multiply. The accumulate variant adds that value to the accumulator. The move variant copies it. The rounded-move variant first clears its low 16 bits, adding one unit at bit 16 when the cleared field was 0x8000 or more. All results appear one clock after the strobe, with a registered valid.

Top module: `xmul_unit`

## Requirements
- R1: Only words with bits [15:13] = 3'b101 are accepted. A word with any other prefix, even while strobed, leaves the product register and both accumulators unchanged and gives no valid_o.
- R2: Bit 12 picks the half of ax0 and bit 11 picks the half of ax1. A value of 1 selects bits [31:16] and a value of 0 selects bits [15:0].
- R3: The raw product is multiplied by two unless mul_nodbl_i is 1.
- R4: With mul_unsigned_i at 0, both selected halves are multiplied as signed 16-bit values, and the result is sign-extended to 40 bits.
- R5: With mul_unsigned_i at 1 and both low halves selected, both values are treated as unsigned.
- R6: With mul_unsigned_i at 1 and exactly one high half selected, call the low-half value L and the high-half value H. If L and H both have bit 15 set, the product is unsigned L times signed H. If only L has bit 15 set, both are unsigned. In every other case both are signed.
- R7: With mul_unsigned_i at 1 and both high halves selected, the product is signed×signed when exactly one value has bit 15 set, and unsigned×unsigned otherwise.
- R8: Bits [10:9] = 00 select the plain multiply, which writes only the product register and leaves both accumulators unchanged.
- R9: Bits [10:9] = 01 select accumulate: accumulator bit 8 becomes its old value plus the old product, modulo 2^40.
- R10: Bits [10:9] = 11 select move: accumulator bit 8 takes the old product.
- R11: Bits [10:9] = 10 select the rounded move. Accumulator bit 8 takes the old product with bits [15:0] cleared, plus 0x10000 if the old bit 15 was 1, modulo 2^40.
- R12: Results and valid_o appear on the clock edge after the accepted strobe. With valid_i at 0, nothing changes.
- R13: Reset clears the product register, both accumulators and valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 16 | Instruction word |
| ax0_i | input | 32 | First auxiliary operand (high:low) |
| ax1_i | input | 32 | Second auxiliary operand (high:low) |
| mul_unsigned_i | input | 1 | Status bit enabling unsigned/mixed handling |
| mul_nodbl_i | input | 1 | Status bit suppressing the doubling |
| valid_o | output | 1 | Registered result valid |
| prod_o | output | 40 | Product register |
| acc0_o | output | 40 | Accumulator 0 |
| acc1_o | output | 40 | Accumulator 1 |

## Verification
Updating an accumulator and writing the new product happen on the same edge. The accumulator must take the product held before that edge, never the one being formed. The bench provokes this by issuing accumulate, move and rounded-move words back to back after multiplies with distinct results. It judges each result against a model that saves the old product before applying the new one. Rounding is provoked with a held product whose low field is exactly 0x8000.

// File: rtl/xmul_pkg.sv
package xmul_pkg;
  parameter int unsigned HALF_W = 16;
  parameter int unsigned ACC_W  = 40;

  typedef enum logic [1:0] {
    SM_SS = 2'd0,  // signed x signed
    SM_UU = 2'd1,  // unsigned x unsigned
    SM_US = 2'd2   // unsigned opa x signed opb
  } sign_mode_e;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_ACC = 2'b01,
    OP_MVZ = 2'b10,
    OP_MOV = 2'b11
  } op_e;

  typedef struct packed {
    logic legal;
    op_e  op;
    logic acc_sel;
    logic ax0_hi;
    logic ax1_hi;
  } dec_t;
endpackage

// File: rtl/xmul_decode.sv
module xmul_decode
  import xmul_pkg::*;
#(
  parameter int unsigned HW = HALF_W
) (
  input  logic [15:0]     instr_i,
  input  logic [2*HW-1:0] ax0_i,
  input  logic [2*HW-1:0] ax1_i,
  input  logic            unsigned_en_i,
  output dec_t            dec_o,
  output logic [HW-1:0]   opa_o,
  output logic [HW-1:0]   opb_o,
  output sign_mode_e      mode_o
);
  logic [HW-1:0] v0, v1;

  always_comb begin
    dec_o.legal   = (instr_i[15:13] == 3'b101);
    dec_o.ax0_hi  = instr_i[12];
    dec_o.ax1_hi  = instr_i[11];
    dec_o.op      = op_e'(instr_i[10:9]);
    dec_o.acc_sel = instr_i[8];
  end

  assign v0 = instr_i[12] ? ax0_i[2*HW-1:HW] : ax0_i[HW-1:0];
  assign v1 = instr_i[11] ? ax1_i[2*HW-1:HW] : ax1_i[HW-1:0];

  // opa holds the low-half value when exactly one high half is picked
  always_comb begin
    opa_o  = v0;
    opb_o  = v1;
    mode_o = SM_SS;
    if (unsigned_en_i) begin
      unique case ({instr_i[12], instr_i[11]})
        2'b00: mode_o = SM_UU;
        2'b11: mode_o = (v0[HW-1] ^ v1[HW-1]) ? SM_SS : SM_UU;
        default: begin
          opa_o = instr_i[12] ? v1 : v0;
          opb_o = instr_i[12] ? v0 : v1;
          if (opa_o[HW-1] && opb_o[HW-1])       mode_o = SM_US;
          else if (opa_o[HW-1])                 mode_o = SM_UU;
          else                                  mode_o = SM_SS;
        end
      endcase
    end
  end

  always_comb begin
    if (!unsigned_en_i) p_signed_only_r4 : assert (mode_o == SM_SS);
  end
endmodule

// File: rtl/xmul_core.sv
module xmul_core
  import xmul_pkg::*;
#(
  parameter int unsigned HW = HALF_W,
  parameter int unsigned AW = ACC_W
) (
  input  logic [HW-1:0] opa_i,
  input  logic [HW-1:0] opb_i,
  input  sign_mode_e    mode_i,
  input  logic          no_dbl_i,
  output logic [AW-1:0] prod_o
);
  localparam int unsigned EW = HW + 1;
  localparam int unsigned PW = 2 * EW;

  logic              sa, sb;
  logic signed [EW-1:0] ea, eb;
  logic signed [PW-1:0] raw;
  logic signed [AW-1:0] ext;

  assign sa  = (mode_i == SM_SS);
  assign sb  = (mode_i == SM_SS) || (mode_i == SM_US);
  assign ea  = $signed({sa & opa_i[HW-1], opa_i});
  assign eb  = $signed({sb & opb_i[HW-1], opb_i});
  assign raw = ea * eb;
  assign ext = AW'(raw);

  generate
    if (AW > PW) begin : g_wide
      assign prod_o = no_dbl_i ? ext : {ext[AW-2:0], 1'b0};
    end else begin : g_narrow
      assign prod_o = no_dbl_i ? raw[AW-1:0] : {raw[AW-2:0], 1'b0};
    end
  endgenerate
endmodule

// File: rtl/xmul_round.sv
module xmul_round
  import xmul_pkg::*;
#(
  parameter int unsigned AW = ACC_W,
  parameter int unsigned HW = HALF_W
) (
  input  logic [AW-1:0] val_i,
  output logic [AW-1:0] rnd_o
);
  localparam logic [AW-1:0] UNIT = AW'(1) << HW;

  assign rnd_o = {val_i[AW-1:HW], {HW{1'b0}}} + (val_i[HW-1] ? UNIT : '0);
endmodule

// File: rtl/xmul_unit.sv
module xmul_unit
  import xmul_pkg::*;
#(
  parameter int unsigned HW = HALF_W,
  parameter int unsigned AW = ACC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [15:0]     instr_i,
  input  logic [2*HW-1:0] ax0_i,
  input  logic [2*HW-1:0] ax1_i,
  input  logic            mul_unsigned_i,
  input  logic            mul_nodbl_i,
  output logic            valid_o,
  output logic [AW-1:0]   prod_o,
  output logic [AW-1:0]   acc0_o,
  output logic [AW-1:0]   acc1_o
);
  localparam int unsigned NACC = 2;

  dec_t          dec;
  logic [HW-1:0] opa, opb;
  sign_mode_e    mode;
  logic [AW-1:0] prod_new, prod_rnd;
  logic [AW-1:0] prod_q;
  logic [AW-1:0] acc_q [NACC];
  logic          valid_q;
  logic          fire;

  xmul_decode #(.HW(HW)) u_dec (
    .instr_i      (instr_i),
    .ax0_i        (ax0_i),
    .ax1_i        (ax1_i),
    .unsigned_en_i(mul_unsigned_i),
    .dec_o        (dec),
    .opa_o        (opa),
    .opb_o        (opb),
    .mode_o       (mode)
  );

  xmul_core #(.HW(HW), .AW(AW)) u_core (
    .opa_i   (opa),
    .opb_i   (opb),
    .mode_i  (mode),
    .no_dbl_i(mul_nodbl_i),
    .prod_o  (prod_new)
  );

  xmul_round #(.AW(AW), .HW(HW)) u_rnd (
    .val_i(prod_q),
    .rnd_o(prod_rnd)
  );

  assign fire = valid_i & dec.legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) prod_q <= prod_new;
    end
  end

  // accumulators consume prod_q before it is overwritten
  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= '0;
      end else if (fire && (dec.acc_sel == 1'(g))) begin
        unique case (dec.op)
          OP_ACC:  acc_q[g] <= acc_q[g] + prod_q;
          OP_MOV:  acc_q[g] <= prod_q;
          OP_MVZ:  acc_q[g] <= prod_rnd;
          default: acc_q[g] <= acc_q[g];
        endcase
      end
    end
  end

  assign valid_o = valid_q;
  assign prod_o  = prod_q;
  assign acc0_o  = acc_q[0];
  assign acc1_o  = acc_q[1];

  p_valid_follows_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  p_idle_hold_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(prod_o) && $stable(acc0_o) && $stable(acc1_o)));
  p_illegal_ignored_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:13] != 3'b101) |=> (!valid_o && $stable(prod_o)
      && $stable(acc0_o) && $stable(acc1_o)));
  p_mulx_keeps_acc_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec.op == OP_MUL) |=> ($stable(acc0_o) && $stable(acc1_o)));
  p_move_copy_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec.op == OP_MOV && !dec.acc_sel) |=> (acc0_o == $past(prod_o)));
  p_round_low_clear_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec.op == OP_MVZ && dec.acc_sel) |=> (acc1_o[HW-1:0] == '0));
  p_double_even_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !mul_nodbl_i) |=> (prod_o[0] == 1'b0));
endmodule

// File: tb/xmul_unit_tb.sv
module xmul_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] ax0_i = '0, ax1_i = '0;
  logic        mul_unsigned_i = 1'b0, mul_nodbl_i = 1'b0;
  logic        valid_o;
  logic [39:0] prod_o, acc0_o, acc1_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [39:0] m_prod = '0;
  logic [39:0] m_acc [2] = '{40'h0, 40'h0};

  always #10 clk_i = ~clk_i;

  xmul_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .instr_i, .ax0_i, .ax1_i,
    .mul_unsigned_i, .mul_nodbl_i, .valid_o, .prod_o, .acc0_o, .acc1_o
  );

  function automatic logic [15:0] mk(bit s, bit t, logic [1:0] op, bit r);
    return {3'b101, s, t, op, r, 8'h00};
  endfunction

  function automatic logic [39:0] ref_prod(logic [15:0] ins, logic [31:0] a0, logic [31:0] a1,
                                           bit u, bit nd);
    bit s = ins[12], t = ins[11];
    logic [15:0] v0 = s ? a0[31:16] : a0[15:0];
    logic [15:0] v1 = t ? a1[31:16] : a1[15:0];
    logic [15:0] l, h;
    longint x, y, p;
    x = longint'($signed(v0)); y = longint'($signed(v1));
    if (u) begin
      if (!s && !t) begin x = longint'(v0); y = longint'(v1); end
      else if (s ^ t) begin
        l = s ? v1 : v0; h = s ? v0 : v1;
        if (l[15] && h[15])  begin x = longint'(l); y = longint'($signed(h)); end
        else if (l[15])      begin x = longint'(l); y = longint'(h); end
        else                 begin x = longint'($signed(l)); y = longint'($signed(h)); end
      end else if (!(v0[15] ^ v1[15])) begin
        x = longint'(v0); y = longint'(v1);
      end
    end
    p = x * y;
    if (!nd) p = p * 2;
    return p[39:0];
  endfunction

  task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [15:0] ins, logic [31:0] a0, logic [31:0] a1,
                      bit u, bit nd, string tag);
    logic [39:0] old;
    bit ok;
    valid_i = v; instr_i = ins; ax0_i = a0; ax1_i = a1;
    mul_unsigned_i = u; mul_nodbl_i = nd;
    @(posedge clk_i);
    ok = v && (ins[15:13] == 3'b101);
    if (ok) begin
      old = m_prod;
      case (ins[10:9])
        2'b01: m_acc[ins[8]] = m_acc[ins[8]] + old;
        2'b11: m_acc[ins[8]] = old;
        2'b10: m_acc[ins[8]] = {old[39:16], 16'h0} + (old[15] ? 40'h10000 : 40'h0);
        default: ;
      endcase
      m_prod = ref_prod(ins, a0, a1, u, nd);
    end
    @(negedge clk_i);
    chk({tag, " valid"}, 40'(valid_o), 40'(ok));
    chk({tag, " prod"}, prod_o, m_prod);
    chk({tag, " acc0"}, acc0_o, m_acc[0]);
    chk({tag, " acc1"}, acc1_o, m_acc[1]);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R13 reset prod", prod_o, '0);
    chk("R13 reset acc0", acc0_o, '0);
    chk("R13 reset acc1", acc1_o, '0);
    chk("R13 reset valid", 40'(valid_o), '0);

    step(1, mk(0,0,2'b00,0), 32'h0000_0003, 32'h0000_0005, 0, 0, "R3 doubled");
    step(1, mk(0,0,2'b00,0), 32'h0000_FFFF, 32'h0000_0002, 0, 1, "R4 signed");
    step(1, mk(0,0,2'b00,0), 32'h0000_FFFF, 32'h0000_0002, 1, 1, "R5 low-low unsigned");
    step(1, mk(0,0,2'b01,0), 32'h0000_FFFF, 32'h0000_FFFF, 1, 0, "R9 accumulate");
    step(1, mk(0,1,2'b00,0), 32'h0000_8000, 32'h8000_0000, 1, 1, "R6 L,H both top");
    step(1, mk(0,1,2'b11,0), 32'h0000_8000, 32'h0003_0000, 1, 1, "R10 move / R6 L top");
    step(1, mk(1,0,2'b10,1), 32'h8000_0000, 32'h0000_0003, 1, 1, "R11 round / R6 H top");
    step(1, mk(1,0,2'b00,0), 32'h7FFF_1234, 32'h5678_0002, 1, 0, "R2 half select");
    step(1, mk(1,1,2'b01,1), 32'hFFFF_0000, 32'hFFFF_0000, 1, 1, "R7 both top");
    step(1, mk(1,1,2'b00,0), 32'hFFFF_0000, 32'h0002_0000, 1, 1, "R7 one top");
    step(1, 16'h0000, 32'h1111_2222, 32'h3333_4444, 1, 0, "R1 illegal");
    step(0, mk(0,0,2'b01,0), 32'h1111_2222, 32'h3333_4444, 0, 0, "R12 idle");
    step(1, mk(0,0,2'b00,0), 32'h0000_0001, 32'h0000_8000, 1, 1, "R8 product only");
    step(1, mk(0,0,2'b00,0), 32'h0000_FFFF, 32'h0000_FFFF, 0, 1, "R12 back-to-back");

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ins = {3'b101, 13'($urandom())};
      string tag;
      if ($urandom_range(9) == 0) ins = 16'($urandom());
      case (ins[10:9])
        2'b00: tag = "R8 rnd";
        2'b01: tag = "R9 rnd";
        2'b11: tag = "R10 rnd";
        default: tag = "R11 rnd";
      endcase
      step($urandom_range(4) != 0, ins, $urandom(), $urandom(),
           1'($urandom()), 1'($urandom()), tag);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule